// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This unit detects read-after-write hazards between the middle and last stages of a three-stage in-order pipeline. Source operands are normally consumed in stage 2, but some results appear only in stage 3: load data and store-conditional status. The unit compares the registers that stage 2 reads with the destination of the instruction in stage 3. When the value will be late, it holds stage 2 for one cycle and marks the following stage-3 slot as a bubble.

Each operand is classified by the stage in which it is actually used. The data operand of a store is consumed in stage 3, next to the load that produces it, so a load followed by a store of that load's result flows through without a stall. A load result used as an address or as a branch compare operand costs one bubble. Results from single-cycle units such as the multiplier are produced early and never stall.

The stall output is combinational within the cycle. The bubble marker is registered and tells stage 3 that the slot it receives on the next cycle holds no instruction. A flush from the branch or trap logic cancels any stall.

Top module: `load_use_interlock`

## Requirements
- R1: While reset is held and on the first cycle after it, `bubble_s3` is 0.
- R2: A valid stage-2 instruction that reads, in stage 2, the destination of a valid load (`s3_kind`=2) in stage 3 raises `stall_s2` in that cycle, and `bubble_s3` is 1 in exactly the next cycle.
- R3: If no enabled source matches the stage-3 destination, `stall_s2` stays 0, so the instruction after a load costs no extra cycle.
- R4: For a store (`s2_kind`=2), operand 2 (`s2_rs2`, the store data) is used in stage 3 and never stalls. Operand 1 (`s2_rs1`, the base address) stalls like any stage-2 use.
- R5: A load (`s2_kind`=1) whose base register `s2_rs1` is the destination of a load in stage 3 stalls for one cycle.
- R6: A store-conditional result in stage 3 (`s3_kind`=3) that a conditional branch (`s2_kind`=3) compares in stage 2 stalls for one cycle.
- R7: A stage-3 producer whose result is ready early (`s3_kind`=1, e.g. multiply or ALU) or that writes nothing (`s3_kind`=0) never causes a stall.
- R8: Register 0 never causes a hazard, whether it is the stage-3 destination or a stage-2 source.
- R9: A source whose read enable (`s2_rs1_ren` or `s2_rs2_ren`) is 0 is not compared.
- R10: When `flush` is 1, `stall_s2` is 0 in that cycle and `bubble_s3` is 0 in the next cycle.
- R11: If `s2_valid` or `s3_valid` is 0, no hazard is reported.
- R12: `hazard_src` bit 0 flags operand 1 and bit 1 flags operand 2 under the rules of R2 to R11, except that `flush` does not mask it. `stall_s2` is 1 only when some bit of `hazard_src` is 1 and `flush` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s2_valid | input | 1 | Stage 2 holds an instruction |
| s2_kind | input | 2 | Consumer class: 0 ALU, 1 load, 2 store, 3 branch |
| s2_rs1 | input | REG_W | Operand 1 register index |
| s2_rs1_ren | input | 1 | Operand 1 is read |
| s2_rs2 | input | REG_W | Operand 2 register index |
| s2_rs2_ren | input | 1 | Operand 2 is read |
| s3_valid | input | 1 | Stage 3 holds an instruction |
| s3_kind | input | 2 | Producer class: 0 no write, 1 early result, 2 load, 3 store-conditional |
| s3_rd | input | REG_W | Stage-3 destination register |
| flush | input | 1 | Pipeline flush; cancels the stall |
| stall_s2 | output | 1 | Hold stage 2 this cycle |
| bubble_s3 | output | 1 | The slot entering stage 3 this cycle is a bubble |
| hazard_src | output | 2 | Per-operand hazard flags |

## Verification
The assertions assume that the surrounding pipeline obeys the stall: after a stall cycle, stage 3 holds a bubble, so a single stall is never followed by a second caused by the same producer. They also assume that the class inputs carry only the four defined codes. The directed bench drives one operand pattern per cycle with every class input inside its legal range. Each pattern is followed by a cycle whose stimulus has no relation to the previous one, so the one-cycle bubble can be seen as a single pulse.

// File: rtl/luh_pkg.sv
package luh_pkg;

    localparam int REG_W_DEF = 5;
    localparam int N_SRC     = 2;

    typedef enum logic [1:0] {
        CK_ALU    = 2'd0,
        CK_LOAD   = 2'd1,
        CK_STORE  = 2'd2,
        CK_BRANCH = 2'd3
    } cons_kind_e;

    typedef enum logic [1:0] {
        PK_NONE  = 2'd0,
        PK_EARLY = 2'd1,
        PK_LOAD  = 2'd2,
        PK_SC    = 2'd3
    } prod_kind_e;

    localparam int STORE_DATA_IDX = 1;

    // Operand consumed in stage 3 (store data) rather than stage 2
    function automatic logic use_is_late(cons_kind_e k, int idx);
        return (k == CK_STORE) && (idx == STORE_DATA_IDX);
    endfunction

    // Producer whose value is only ready in stage 3
    function automatic logic result_is_late(prod_kind_e k);
        return (k == PK_LOAD) || (k == PK_SC);
    endfunction

endpackage

// File: rtl/luh_use_class.sv
module luh_use_class
    import luh_pkg::*;
(
    input  cons_kind_e             kind,
    output logic [N_SRC-1:0]       early_use
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_op
        assign early_use[i] = !use_is_late(kind, i);
    end
endmodule

// File: rtl/luh_src_cmp.sv
module luh_src_cmp #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             ren,
    input  logic             early_use,
    input  logic [REG_W-1:0] dst,
    input  logic             dst_late,
    output logic             hit
);
    logic src_nz;
    assign src_nz = |src;
    assign hit    = ren && early_use && dst_late && src_nz && (src == dst);
endmodule

// File: rtl/luh_stall_ctl.sv
module luh_stall_ctl
    import luh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] hits,
    input  logic             flush,
    output logic             stall,
    output logic             bubble_q
);
    assign stall = (|hits) && !flush;

    always_ff @(posedge clk) begin
        if (rst) bubble_q <= 1'b0;
        else     bubble_q <= stall;
    end
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
    import luh_pkg::*;
#(
    parameter int REG_W = REG_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s2_valid,
    input  logic [1:0]       s2_kind,
    input  logic [REG_W-1:0] s2_rs1,
    input  logic             s2_rs1_ren,
    input  logic [REG_W-1:0] s2_rs2,
    input  logic             s2_rs2_ren,
    input  logic             s3_valid,
    input  logic [1:0]       s3_kind,
    input  logic [REG_W-1:0] s3_rd,
    input  logic             flush,
    output logic             stall_s2,
    output logic             bubble_s3,
    output logic [1:0]       hazard_src
);
    logic [REG_W-1:0] src_idx [N_SRC];
    logic [N_SRC-1:0] src_ren;
    logic [N_SRC-1:0] early_use;
    logic [N_SRC-1:0] hits;
    logic             dst_late;
    logic             dst_nz;

    assign src_idx[0] = s2_rs1;
    assign src_idx[1] = s2_rs2;
    assign src_ren    = {s2_rs2_ren, s2_rs1_ren} & {N_SRC{s2_valid}};
    assign dst_nz     = |s3_rd;
    assign dst_late   = s3_valid && dst_nz && result_is_late(prod_kind_e'(s3_kind));

    luh_use_class u_class (
        .kind      (cons_kind_e'(s2_kind)),
        .early_use (early_use)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
        luh_src_cmp #(.REG_W(REG_W)) u_cmp (
            .src       (src_idx[i]),
            .ren       (src_ren[i]),
            .early_use (early_use[i]),
            .dst       (s3_rd),
            .dst_late  (dst_late),
            .hit       (hits[i])
        );
    end

    luh_stall_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .hits     (hits),
        .flush    (flush),
        .stall    (stall_s2),
        .bubble_q (bubble_s3)
    );

    assign hazard_src = hits;
endmodule

// File: rtl/load_use_interlock_chk.sv
module load_use_interlock_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             s2_valid,
    input logic [1:0]       s2_kind,
    input logic [REG_W-1:0] s2_rs1,
    input logic             s2_rs1_ren,
    input logic [REG_W-1:0] s2_rs2,
    input logic             s2_rs2_ren,
    input logic             s3_valid,
    input logic [1:0]       s3_kind,
    input logic [REG_W-1:0] s3_rd,
    input logic             flush,
    input logic             stall_s2,
    input logic             bubble_s3,
    input logic [1:0]       hazard_src
);
    // R2
    stall_then_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        stall_s2 |=> bubble_s3);

    // R2
    bubble_needs_stall_chk: assert property (@(posedge clk) disable iff (rst)
        bubble_s3 |-> $past(stall_s2));

    // R10
    flush_blocks_stall_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !stall_s2);

    // R10
    flush_no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !bubble_s3);

    // R8
    x0_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (s3_rd == '0) |-> (hazard_src == 2'b00));

    // R4
    store_data_free_chk: assert property (@(posedge clk) disable iff (rst)
        (s2_kind == 2'd2) |-> !hazard_src[1]);

    // R7
    early_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (s3_kind inside {2'd0, 2'd1}) |-> !stall_s2);

    // R11
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!s2_valid || !s3_valid) |-> (hazard_src == 2'b00));

    // R12
    stall_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        stall_s2 |-> (hazard_src != 2'b00));
endmodule

bind load_use_interlock load_use_interlock_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/load_use_interlock_bench.sv
module load_use_interlock_bench;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          s2_valid;
    logic [1:0]    s2_kind;
    logic [RW-1:0] s2_rs1;
    logic          s2_rs1_ren;
    logic [RW-1:0] s2_rs2;
    logic          s2_rs2_ren;
    logic          s3_valid;
    logic [1:0]    s3_kind;
    logic [RW-1:0] s3_rd;
    logic          flush;
    logic          stall_s2;
    logic          bubble_s3;
    logic [1:0]    hazard_src;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    load_use_interlock #(.REG_W(RW)) u_load_use_interlock (.*);

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(logic v2, logic [1:0] k2, logic [RW-1:0] a, logic ae,
                         logic [RW-1:0] b, logic be, logic v3, logic [1:0] k3,
                         logic [RW-1:0] d, logic f);
        @(negedge clk);
        s2_valid = v2; s2_kind = k2; s2_rs1 = a; s2_rs1_ren = ae;
        s2_rs2 = b; s2_rs2_ren = be; s3_valid = v3; s3_kind = k3;
        s3_rd = d; flush = f;
        #1;
    endtask

    // Apply one pattern, check comb outputs, then the bubble on the next cycle
    task automatic step(string tag, logic v2, logic [1:0] k2, logic [RW-1:0] a,
                        logic ae, logic [RW-1:0] b, logic be, logic v3,
                        logic [1:0] k3, logic [RW-1:0] d, logic f,
                        logic exp_stall, logic [1:0] exp_src);
        drive(v2, k2, a, ae, b, be, v3, k3, d, f);
        chk({tag, " stall"}, {1'b0, stall_s2}, {1'b0, exp_stall});
        chk({tag, " src"}, hazard_src, exp_src);
        @(posedge clk); #1;
        chk({tag, " bubble"}, {1'b0, bubble_s3}, {1'b0, exp_stall});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(1, 0, 5, 1, 0, 0, 1, 2, 5, 0);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 during reset", {1'b0, bubble_s3}, 2'b00);
        @(negedge clk); rst = 1'b0;
        s2_valid = 0; s3_valid = 0;
        @(posedge clk); #1;
        chk("R1 after reset", {1'b0, bubble_s3}, 2'b00);
    endtask

    task automatic t_load_use();
        step("R2 alu after load", 1, 0, 5, 1, 0, 0, 1, 2, 5, 0, 1, 2'b01);
        step("R2 single bubble", 1, 0, 5, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00);
    endtask

    task automatic t_independent();
        step("R3 independent", 1, 0, 6, 1, 7, 1, 1, 2, 5, 0, 0, 2'b00);
    endtask

    task automatic t_store();
        step("R4 store data", 1, 2, 3, 1, 5, 1, 1, 2, 5, 0, 0, 2'b00);
        step("R4 store base", 1, 2, 5, 1, 3, 1, 1, 2, 5, 0, 1, 2'b01);
    endtask

    task automatic t_load_base();
        step("R5 load base", 1, 1, 9, 1, 0, 0, 1, 2, 9, 0, 1, 2'b01);
    endtask

    task automatic t_sc_branch();
        step("R6 sc to branch", 1, 3, 8, 1, 4, 1, 1, 3, 4, 0, 1, 2'b10);
    endtask

    task automatic t_early();
        step("R7 early producer", 1, 0, 4, 1, 0, 0, 1, 1, 4, 0, 0, 2'b00);
        step("R7 no-write producer", 1, 3, 4, 1, 4, 1, 1, 0, 4, 0, 0, 2'b00);
    endtask

    task automatic t_x0();
        step("R8 x0", 1, 0, 0, 1, 0, 1, 1, 2, 0, 0, 0, 2'b00);
    endtask

    task automatic t_ren();
        step("R9 rs1 not read", 1, 0, 6, 0, 7, 1, 1, 2, 6, 0, 0, 2'b00);
        step("R9 rs2 not read", 1, 3, 1, 1, 6, 0, 1, 2, 6, 0, 0, 2'b00);
    endtask

    task automatic t_flush();
        step("R10 flush", 1, 0, 5, 1, 0, 0, 1, 2, 5, 1, 0, 2'b01);
    endtask

    task automatic t_valid();
        step("R11 s2 invalid", 0, 0, 5, 1, 5, 1, 1, 2, 5, 0, 0, 2'b00);
        step("R11 s3 invalid", 1, 0, 5, 1, 5, 1, 0, 2, 5, 0, 0, 2'b00);
    endtask

    task automatic t_both();
        step("R12 both operands", 1, 0, 7, 1, 7, 1, 1, 2, 7, 0, 1, 2'b11);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_load_use();
                t_independent();
                t_store();
                t_load_base();
                t_sc_branch();
                t_early();
                t_x0();
                t_ren();
                t_flush();
                t_valid();
                t_both();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule